// File: doc/BRIEF.md
# Processor Status and Privilege Control

This block holds a 32-bit processor status word that software reads and writes through a simple port. It owns the interrupt enable and mask fields, the privilege-mode fields, the per-mode 64-bit enables and a handful of status and condition flags. Two hardware event inputs update flags directly. One reports that more than one translation entry matched the same virtual address. The other reports entry into a soft reset or non-maskable interrupt.

From the stored word the block decodes several combinational outputs. These are a per-line gated interrupt request, the current privilege mode, 64-bit addressing and operation enables for that mode, and a permission check for an access to a classified address region. The fault output flags any access that the current mode may not make. Writes take effect at the clock edge, and every decoded output follows the stored word in the same cycle.

Top module: `psr_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00400004. Bit 2 (error level) and bit 22 (bootstrap vector select) are 1, and every other bit is 0.
- R2: Bits 19 and 31:23 are reserved. A write to them has no effect, and they always read as 0.
- R3: Bit 21 is the translation shutdown flag. Software cannot change it. It becomes 1 in the cycle after tlb_multi_hit is high, and it then stays 1 through any later write until rst.
- R4: Bit 20 is the soft-reset/NMI flag. It becomes 1 in the cycle after sreset_nmi is high, even when a write of 0 to it arrives in the same cycle. At other times software reads and writes it freely.
- R5: Bits 18 (condition), 17 and 16 (compatibility) and 22 (bootstrap vector select) are read/write storage. Hardware never changes bit 18, and bits 17:16 have no effect on any output.
- R6: The field layout is IE at bit 0, EXL at bit 1, ERL at bit 2 and IM at bits 15:8. irq_req[n] is 1 exactly when IE=1, EXL=0, ERL=0, IM[n]=1 and irq_pending[n]=1.
- R7: KSU is at bits 4:3. priv_mode is 00 (kernel) when EXL=1, ERL=1 or KSU=00. Otherwise it is 01 (supervisor) when KSU=01, and 10 (user) when KSU is 10 or 11.
- R8: UX is at bit 5, SX at bit 6 and KX at bit 7. In kernel mode addr64_en=KX and ops64_en=1. In supervisor mode both outputs equal SX, and in user mode both equal UX.
- R9: The region encoding is 00 user, 01 supervisor, and 10 or 11 kernel. access_fault is 1 only when access_req=1 and the current mode may not reach the region. A kernel region needs kernel mode, a supervisor region needs supervisor or kernel mode, and a user region is open to every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current status word |
| tlb_multi_hit | input | 1 | Multiple translation match event |
| sreset_nmi | input | 1 | Soft reset / NMI entry event |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_req | output | 8 | Gated interrupt requests |
| priv_mode | output | 2 | Current privilege mode |
| addr64_en | output | 1 | 64-bit addressing enabled for current mode |
| ops64_en | output | 1 | 64-bit operations enabled for current mode |
| region | input | 2 | Address region class of the access |
| access_req | input | 1 | Access being checked |
| access_fault | output | 1 | Access not permitted in current mode |

## Verification
The bench builds the block with its default 32-bit word and eight interrupt lines. It sweeps all 256 values of the low control byte, so every combination of IE, EXL, ERL, KSU, UX, SX and KX is covered. At each value it checks the mode, the interrupt gating, the 64-bit enables and all four region classes, with the mask, pending and compatibility bits varying alongside. Directed sequences cover the sticky shutdown flag across writes and reset, the priority of the soft-reset event over a same-cycle write, and a write of all ones against the reserved bits.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DATA_W = 32;
  localparam int IRQ_W  = 8;

  localparam int B_IE   = 0;
  localparam int B_EXL  = 1;
  localparam int B_ERL  = 2;
  localparam int B_KSU  = 3;
  localparam int B_UX   = 5;
  localparam int B_SX   = 6;
  localparam int B_KX   = 7;
  localparam int B_IM   = 8;
  localparam int B_CH   = 18;
  localparam int B_SR   = 20;
  localparam int B_TS   = 21;
  localparam int B_BEV  = 22;

  localparam logic [DATA_W-1:0] WR_MASK = 32'h0057_FFFF;
  localparam logic [DATA_W-1:0] RST_VAL = 32'h0040_0004;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_USER   = 2'b10
  } priv_e;

  typedef enum logic [1:0] {
    RGN_USER   = 2'b00,
    RGN_SUPER  = 2'b01,
    RGN_KERNEL = 2'b10,
    RGN_KALT   = 2'b11
  } region_e;
endpackage

// File: rtl/psr_regfile.sv
module psr_regfile
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tlb_multi_hit,
  input  logic              sreset_nmi,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] q, nxt;

  always_comb begin
    nxt = wr_en ? (wr_data & WR_MASK) : (q & WR_MASK);
    nxt[B_TS] = q[B_TS] | tlb_multi_hit;
    if (sreset_nmi) nxt[B_SR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt;
  end

  assign status_q = q;

  assert_ts_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    q[B_TS] |=> q[B_TS]);
  assert_ts_set_R3: assert property (@(posedge clk) disable iff (rst)
    tlb_multi_hit |=> q[B_TS]);
  assert_sr_event_R4: assert property (@(posedge clk) disable iff (rst)
    sreset_nmi |=> q[B_SR]);
  assert_ch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q[B_CH]));
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate
  import psr_pkg::*;
(
  input  logic [DATA_W-1:0] status,
  input  logic [IRQ_W-1:0]  pending,
  output logic [IRQ_W-1:0]  irq_req
);
  logic global_en;
  assign global_en = status[B_IE] & ~status[B_EXL] & ~status[B_ERL];

  for (genvar n = 0; n < IRQ_W; n++) begin : g_line
    assign irq_req[n] = global_en & status[B_IM+n] & pending[n];
  end
endmodule

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
(
  input  logic [DATA_W-1:0] status,
  output priv_e             mode,
  output logic              addr64,
  output logic              ops64
);
  logic [1:0] ksu;
  assign ksu = status[B_KSU+:2];

  always_comb begin
    if (status[B_EXL] || status[B_ERL] || ksu == 2'b00) mode = MODE_KERNEL;
    else if (ksu == 2'b01)                              mode = MODE_SUPER;
    else                                                mode = MODE_USER;
  end

  always_comb begin
    unique case (mode)
      MODE_KERNEL: begin addr64 = status[B_KX]; ops64 = 1'b1;         end
      MODE_SUPER:  begin addr64 = status[B_SX]; ops64 = status[B_SX]; end
      default:     begin addr64 = status[B_UX]; ops64 = status[B_UX]; end
    endcase
  end
endmodule

// File: rtl/psr_access_check.sv
module psr_access_check
  import psr_pkg::*;
(
  input  priv_e      mode,
  input  logic [1:0] region,
  input  logic       access_req,
  output logic       fault
);
  logic allowed;
  always_comb begin
    case (region)
      RGN_USER:  allowed = 1'b1;
      RGN_SUPER: allowed = (mode != MODE_USER);
      default:   allowed = (mode == MODE_KERNEL);
    endcase
  end
  assign fault = access_req & ~allowed;
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tlb_multi_hit,
  input  logic              sreset_nmi,
  input  logic [IRQ_W-1:0]  irq_pending,
  output logic [IRQ_W-1:0]  irq_req,
  output logic [1:0]        priv_mode,
  output logic              addr64_en,
  output logic              ops64_en,
  input  logic [1:0]        region,
  input  logic              access_req,
  output logic              access_fault
);
  logic [DATA_W-1:0] status;
  priv_e             mode;

  psr_regfile u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tlb_multi_hit(tlb_multi_hit), .sreset_nmi(sreset_nmi), .status_q(status));

  psr_irq_gate u_irq (.status(status), .pending(irq_pending), .irq_req(irq_req));

  psr_mode_decode u_mode (.status(status), .mode(mode),
    .addr64(addr64_en), .ops64(ops64_en));

  psr_access_check u_acc (.mode(mode), .region(region),
    .access_req(access_req), .fault(access_fault));

  assign rd_data   = status;
  assign priv_mode = mode;

  assert_fault_not_kernel_R9: assert property (@(posedge clk) disable iff (rst)
    access_fault |-> priv_mode != MODE_KERNEL);
  assert_ops64_kernel_R8: assert property (@(posedge clk) disable iff (rst)
    !ops64_en |-> priv_mode != MODE_KERNEL);
  assert_irq_not_err_R6: assert property (@(posedge clk) disable iff (rst)
    (|irq_req) |-> !rd_data[B_ERL]);
  assert_user_region_open_R9: assert property (@(posedge clk) disable iff (rst)
    (region == 2'b00) |-> !access_fault);
endmodule

// File: tb/psr_ctrl_bench.sv
module psr_ctrl_bench;
  logic clk = 0, rst = 1, wr_en = 0, tlb_multi_hit = 0, sreset_nmi = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [7:0] irq_pending = 0, irq_req;
  logic [1:0] priv_mode, region = 0;
  logic addr64_en, ops64_en, access_req = 0, access_fault;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psr_ctrl u_psr_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset value", rd_data, 32'h0040_0004);
    chk("R7 reset mode kernel", {30'd0, priv_mode}, 32'd0);

    wr(32'hFFFF_FFFF);
    chk("R2 reserved read zero", rd_data, 32'h0057_FFFF);
    wr(32'h0020_0000);
    chk("R3 TS not writable", {31'd0, rd_data[21]}, 32'd0);

    @(negedge clk); tlb_multi_hit = 1;
    @(negedge clk); tlb_multi_hit = 0;
    chk("R3 TS set by event", {31'd0, rd_data[21]}, 32'd1);
    wr(32'h0000_0000);
    chk("R3 TS sticky across write", rd_data, 32'h0020_0000);

    wr(32'h0010_0000);
    chk("R4 SR software set", {31'd0, rd_data[20]}, 32'd1);
    wr(32'h0000_0000);
    chk("R4 SR software clear", {31'd0, rd_data[20]}, 32'd0);
    @(negedge clk); wr_en = 1; wr_data = 32'h0; sreset_nmi = 1;
    @(negedge clk); wr_en = 0; sreset_nmi = 0;
    chk("R4 SR event beats write", {31'd0, rd_data[20]}, 32'd1);
    @(negedge clk);
    chk("R4 SR holds", {31'd0, rd_data[20]}, 32'd1);

    wr(32'h0044_0000);
    chk("R5 CH and BEV stored", rd_data, 32'h0064_0000);
    repeat (3) @(negedge clk);
    chk("R5 CH held by hardware", {31'd0, rd_data[18]}, 32'd1);

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R3 reset clears TS", rd_data, 32'h0040_0004);

    for (int i = 0; i < 256; i++) begin
      logic [7:0] lo, im, pend, exp_irq;
      logic [1:0] ksu, exp_mode;
      logic exl, erl, ie, ux, sx, kx, exp_a, exp_o;
      logic [31:0] w;
      lo = i[7:0];
      im = lo ^ 8'h5A;
      pend = ~lo + 8'd37;
      w = {14'd0, lo[6:5], im, lo};
      ie = lo[0]; exl = lo[1]; erl = lo[2]; ksu = lo[4:3];
      ux = lo[5]; sx = lo[6]; kx = lo[7];
      irq_pending = pend;
      wr(w);
      chk("R5 sweep readback", rd_data, w);
      exp_irq = (ie && !exl && !erl) ? (im & pend) : 8'h00;
      chk("R6 irq gating", {24'd0, irq_req}, {24'd0, exp_irq});
      if (exl || erl || ksu == 2'b00) begin
        exp_mode = 2'b00; exp_a = kx; exp_o = 1'b1;
      end else if (ksu == 2'b01) begin
        exp_mode = 2'b01; exp_a = sx; exp_o = sx;
      end else begin
        exp_mode = 2'b10; exp_a = ux; exp_o = ux;
      end
      chk("R7 mode decode", {30'd0, priv_mode}, {30'd0, exp_mode});
      chk("R8 addr64", {31'd0, addr64_en}, {31'd0, exp_a});
      chk("R8 ops64", {31'd0, ops64_en}, {31'd0, exp_o});
      for (int r = 0; r < 4; r++) begin
        logic exp_f;
        region = r[1:0];
        access_req = 1;
        if (r == 0) exp_f = 0;
        else if (r == 1) exp_f = (exp_mode == 2'b10);
        else exp_f = (exp_mode != 2'b00);
        #1;
        chk("R9 access fault", {31'd0, access_fault}, {31'd0, exp_f});
        access_req = 0;
        #1;
        chk("R9 no request no fault", {31'd0, access_fault}, 32'd0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule